// File: doc/BRIEF.md
# Hit Word Packet Segmenter

The segmenter sits between a pixel front end and an existing readout stage. It accepts one 112-bit hit word at a time over a valid/ready handshake and turns it into a run of 12-bit packets, one per clock. Each packet holds an 11-bit data field and a stop flag that marks the final packet of the record. The number of packets comes from a length field that travels with the word. The write-enable strobe that qualifies each packet drops for exactly one clock after every record. The readout logic downstream relies on that gap to find record boundaries.

A front end with nothing to report raises an empty flag together with its valid strobe. The segmenter then sends a one-packet record whose stop flag is set. Every real hit record is at least two packets long, so a lone packet is never mistaken for hit data. A configuration bit chooses the data field of that marker: either all zeros or the historical empty-event code 0x7FD.

Top module: `hit_word_segmenter`

## Requirements
- R1: While reset is asserted and until it has been released for two clock edges, `pkt_we` and `in_ready` are both low. After that, `in_ready` is high and `pkt_we` is low.
- R2: A word is accepted on a rising edge where `in_valid` and `in_ready` are both high. Its first packet appears with `pkt_we` high in the cycle that follows, and one packet follows per cycle after that.
- R3: `pkt_data[10:0]` is the data field and `pkt_data[11]` is the stop flag. Packet k (counting from 0) carries word bits [111-11k : 101-11k], taken most-significant end first. The last possible packet (k=10) carries word bits [1:0] in its top two bits, and its low nine bits are zero.
- R4: `in_len` (4 bits) gives the number of packets in a hit record. Values below 2 are sent as 2 packets, and values above 11 are sent as 11 packets.
- R5: The stop flag is 1 on the last packet of a record and 0 on every earlier packet.
- R6: After the last packet of each record, `pkt_we` is low for exactly one cycle when the next word is offered at once. In that case the next record's first packet follows that single gap cycle.
- R7: A word accepted with `in_empty`=1 yields exactly one packet with stop flag 1. Its data field is 0x7FD when `cfg_legacy_empty` was 1 at acceptance, and 0x000 otherwise. `in_word` and `in_len` have no effect on this packet.
- R8: `in_ready` is low from the cycle after acceptance through the cycle of the last packet. It is high in the gap cycle and while idle.
- R9: The word, length, empty flag and configuration bit are captured at acceptance. Changing any of them while a record is being sent does not alter that record's packets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | A hit word is offered |
| in_ready | output | 1 | The segmenter can accept a word this cycle |
| in_word | input | 112 | Hit word, sent most-significant end first |
| in_len | input | 4 | Packet count of a hit record, clamped to 2..11 |
| in_empty | input | 1 | The offered word stands for an event with no hits |
| cfg_legacy_empty | input | 1 | Selects 0x7FD (1) or 0x000 (0) as the empty-marker data |
| pkt_we | output | 1 | Packet write enable |
| pkt_data | output | 12 | Bit 11 is the stop flag, bits 10:0 are data |

## Verification
The bench builds the block with its default widths: a 112-bit word, 11-bit data fields and a 4-bit length. Under these widths eleven packets cover the word with nine padding bits, and every length code from 0 to 15 can be driven. This reaches both clamp directions and the padded final packet. It also covers two-packet records sent back to back, where the single-cycle gap and the early return of `in_ready` matter most. Empty markers under both settings of the configuration bit are mixed between hit records, and inputs are scrambled right after each acceptance.

// File: rtl/hws_pkg.sv
package hws_pkg;
  localparam int unsigned HWS_WORD_W = 112;
  localparam int unsigned HWS_DATA_W = 11;
  localparam logic [10:0] HWS_LEGACY_EMPTY = 11'h7FD;

  typedef enum logic [1:0] {
    SEG_IDLE = 2'd0,
    SEG_SEND = 2'd1,
    SEG_GAP  = 2'd2
  } seg_state_e;
endpackage

// File: rtl/hws_len_norm.sv
module hws_len_norm #(
  parameter int unsigned LEN_W    = 4,
  parameter int unsigned MIN_PKTS = 2,
  parameter int unsigned MAX_PKTS = 11
) (
  input  logic [LEN_W-1:0] len_raw,
  input  logic             empty,
  output logic [LEN_W-1:0] last_idx
);
  localparam logic [LEN_W-1:0] MIN_L = LEN_W'(MIN_PKTS);
  localparam logic [LEN_W-1:0] MAX_L = LEN_W'(MAX_PKTS);

  always_comb begin
    if (empty) begin
      last_idx = '0;
    end else if (len_raw < MIN_L) begin
      last_idx = MIN_L - 1'b1;
    end else if (len_raw > MAX_L) begin
      last_idx = MAX_L - 1'b1;
    end else begin
      last_idx = len_raw - 1'b1;
    end
  end
endmodule

// File: rtl/hws_pkt_shift.sv
module hws_pkt_shift #(
  parameter int unsigned WORD_W = 112,
  parameter int unsigned DATA_W = 11,
  parameter int unsigned SLOTS  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              advance,
  input  logic [WORD_W-1:0] word_in,
  output logic [DATA_W-1:0] head
);
  localparam int unsigned PAD_W = SLOTS * DATA_W;

  logic [PAD_W-1:0] padded;
  logic [PAD_W-1:0] sh_q;
  logic [PAD_W-1:0] sh_n;

  generate
    if (PAD_W > WORD_W) begin : g_pad
      assign padded = {word_in, {(PAD_W - WORD_W){1'b0}}};
    end else begin : g_exact
      assign padded = word_in[WORD_W-1 -: PAD_W];
    end
  endgenerate

  always_comb begin
    sh_n = sh_q;
    if (load) begin
      sh_n = padded;
    end else if (advance) begin
      sh_n = sh_q << DATA_W;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else if (load || advance) begin
      sh_q <= sh_n;
    end
  end

  assign head = sh_q[PAD_W-1 -: DATA_W];

  // R3: the first slot after a load is the top of the offered word
  a_r3_head_after_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> head == $past(word_in[WORD_W-1 -: DATA_W]));

  // R9: nothing but a load or an advance moves the slot on
  a_r9_head_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !advance) |=> $stable(head));
endmodule

// File: rtl/hws_ctrl.sv
module hws_ctrl
  import hws_pkg::*;
#(
  parameter int unsigned LEN_W = 4,
  parameter int unsigned SLOTS = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_empty,
  input  logic [LEN_W-1:0] last_idx_in,
  output logic             in_ready,
  output logic             load,
  output logic             advance,
  output logic             pkt_we,
  output logic             pkt_stop,
  output logic             empty_q
);
  localparam logic [LEN_W-1:0] TOP_IDX = LEN_W'(SLOTS - 1);

  seg_state_e       state_q, state_n;
  logic [LEN_W-1:0] cnt_q, cnt_n;
  logic [LEN_W-1:0] last_q, last_n;
  logic             empty_n;

  assign in_ready = rst_n && (state_q != SEG_SEND);
  assign load     = in_ready && in_valid;
  assign pkt_we   = (state_q == SEG_SEND);
  assign pkt_stop = pkt_we && (cnt_q == last_q);
  assign advance  = pkt_we && !pkt_stop;

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    last_n  = last_q;
    empty_n = empty_q;
    case (state_q)
      SEG_SEND: begin
        if (pkt_stop) begin
          state_n = SEG_GAP;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end
      default: begin
        if (load) begin
          state_n = SEG_SEND;
          cnt_n   = '0;
          last_n  = last_idx_in;
          empty_n = in_empty;
        end else begin
          state_n = SEG_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEG_IDLE;
      cnt_q   <= '0;
      last_q  <= '0;
      empty_q <= 1'b0;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      if (load) begin
        last_q  <= last_n;
        empty_q <= empty_n;
      end
    end
  end

  // R4: a record never runs past the last slot of the word
  a_r4_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_we |-> (cnt_q <= last_q) && (last_q <= TOP_IDX));

  // R5: a packet without stop is always followed by another packet
  a_r5_no_early_end: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_we && !pkt_stop) |=> pkt_we);
endmodule

// File: rtl/hit_word_segmenter.sv
module hit_word_segmenter
  import hws_pkg::*;
#(
  parameter int unsigned WORD_W   = HWS_WORD_W,
  parameter int unsigned DATA_W   = HWS_DATA_W,
  parameter int unsigned LEN_W    = 4,
  parameter int unsigned MIN_PKTS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_word,
  input  logic [LEN_W-1:0]  in_len,
  input  logic              in_empty,
  input  logic              cfg_legacy_empty,
  output logic              pkt_we,
  output logic [DATA_W:0]   pkt_data
);
  localparam int unsigned SLOTS = (WORD_W + DATA_W - 1) / DATA_W;
  localparam logic [DATA_W-1:0] EMPTY_CODE = DATA_W'(HWS_LEGACY_EMPTY);

  logic [1:0]        rst_pipe;
  logic              rst_sync;
  logic [LEN_W-1:0]  last_idx;
  logic              load;
  logic              advance;
  logic              pkt_stop;
  logic              empty_q;
  logic [DATA_W-1:0] head;
  logic [DATA_W-1:0] code_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe <= '0;
    end else begin
      rst_pipe <= {rst_pipe[0], 1'b1};
    end
  end
  assign rst_sync = rst_pipe[1];

  hws_len_norm #(
    .LEN_W(LEN_W), .MIN_PKTS(MIN_PKTS), .MAX_PKTS(SLOTS)
  ) u_len (
    .len_raw(in_len), .empty(in_empty), .last_idx(last_idx)
  );

  hws_ctrl #(
    .LEN_W(LEN_W), .SLOTS(SLOTS)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_sync), .in_valid(in_valid), .in_empty(in_empty),
    .last_idx_in(last_idx), .in_ready(in_ready), .load(load),
    .advance(advance), .pkt_we(pkt_we), .pkt_stop(pkt_stop), .empty_q(empty_q)
  );

  hws_pkt_shift #(
    .WORD_W(WORD_W), .DATA_W(DATA_W), .SLOTS(SLOTS)
  ) u_shift (
    .clk(clk), .rst_n(rst_sync), .load(load), .advance(advance),
    .word_in(in_word), .head(head)
  );

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) begin
      code_q <= '0;
    end else if (load) begin
      code_q <= cfg_legacy_empty ? EMPTY_CODE : '0;
    end
  end

  assign pkt_data = {pkt_stop, (empty_q ? code_q : head)};

  // R2: an accepted word shows its first packet on the next cycle
  a_r2_first_packet: assert property (@(posedge clk) disable iff (!rst_sync)
    (in_valid && in_ready) |=> pkt_we);

  // R8: no second word is taken while the first is being sent
  a_r8_ready_drops: assert property (@(posedge clk) disable iff (!rst_sync)
    (in_valid && in_ready) |=> !in_ready);

  // R6: the stop packet is always followed by a cycle without write enable
  a_r6_gap_after_stop: assert property (@(posedge clk) disable iff (!rst_sync)
    (pkt_we && pkt_data[DATA_W]) |=> !pkt_we);

  // R7: an empty marker is a single packet carrying the stop flag
  a_r7_empty_single: assert property (@(posedge clk) disable iff (!rst_sync)
    (in_valid && in_ready && in_empty) |=> pkt_we && pkt_data[DATA_W]);
endmodule

// File: tb/hit_word_segmenter_bench.sv
module hit_word_segmenter_bench;
  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [111:0] in_word;
  logic [3:0]   in_len;
  logic         in_empty;
  logic         cfg_legacy_empty;
  logic         pkt_we;
  logic [11:0]  pkt_data;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  done     = 1'b0;

  hit_word_segmenter u_hit_word_segmenter (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_len(in_len), .in_empty(in_empty),
    .cfg_legacy_empty(cfg_legacy_empty), .pkt_we(pkt_we), .pkt_data(pkt_data)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int pkt_count(input int len, input bit empty);
    if (empty) return 1;
    if (len < 2) return 2;
    if (len > 11) return 11;
    return len;
  endfunction

  function automatic logic [10:0] slot(input logic [111:0] w, input int k);
    logic [120:0] p;
    p = {w, 9'b0};
    return p[120 - 11*k -: 11];
  endfunction

  function automatic logic [111:0] rand_word();
    return {$urandom(), $urandom(), $urandom(), 16'($urandom())};
  endfunction

  // Called at a falling edge with in_ready expected high; returns at the gap cycle.
  task automatic run_rec(input logic [111:0] w, input int len,
                         input bit empty, input bit legacy);
    int n;
    logic [11:0] exp;
    n = pkt_count(len, empty);
    in_word = w; in_len = 4'(len); in_empty = empty;
    cfg_legacy_empty = legacy; in_valid = 1'b1;
    check("R8", "ready before accept", 32'(in_ready), 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    in_word = ~w; in_len = ~4'(len); in_empty = ~empty;
    cfg_legacy_empty = ~legacy;
    for (int k = 0; k < n; k++) begin
      if (empty) exp = {1'b1, (legacy ? 11'h7FD : 11'h000)};
      else       exp = {(k == n - 1), slot(w, k)};
      check(empty ? "R7" : "R2", "we during record", 32'(pkt_we), 32'd1);
      check(empty ? "R7" : (k == n - 1 ? "R5" : "R3"), "packet",
            32'(pkt_data), 32'(exp));
      check("R8", "ready while sending", 32'(in_ready), 32'd0);
      @(negedge clk);
    end
    check("R6", "we in gap", 32'(pkt_we), 32'd0);
    check("R8", "ready in gap", 32'(in_ready), 32'd1);
  endtask

  task automatic idle(input int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check("R6", "we while idle", 32'(pkt_we), 32'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [111:0] w;
    void'($urandom(32'd20160616));
    rst_n = 1'b0; in_valid = 1'b0; in_word = '0; in_len = '0;
    in_empty = 1'b0; cfg_legacy_empty = 1'b0;
    repeat (3) @(negedge clk);
    // R1: held in reset
    check("R1", "we in reset", 32'(pkt_we), 32'd0);
    check("R1", "ready in reset", 32'(in_ready), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "ready during release", 32'(in_ready), 32'd0);
    @(negedge clk);
    @(negedge clk);
    check("R1", "ready after release", 32'(in_ready), 32'd1);
    check("R1", "we after release", 32'(pkt_we), 32'd0);

    // R3 and R5: full word, eleven packets including the padded one
    w = {16'hA5C3, 32'h0123_4567, 32'h89AB_CDEF, 32'hFEDC_BA98};
    run_rec(w, 11, 1'b0, 1'b0);
    idle(2);
    // R3: all ones exposes the zero padding of the last slot
    run_rec({112{1'b1}}, 11, 1'b0, 1'b0);
    // R6: shortest record straight after, then back to back
    run_rec(rand_word(), 2, 1'b0, 1'b0);
    run_rec(rand_word(), 2, 1'b0, 1'b0);
    // R4: clamp below and above
    run_rec(rand_word(), 0, 1'b0, 1'b0);
    run_rec(rand_word(), 1, 1'b0, 1'b0);
    run_rec(rand_word(), 15, 1'b0, 1'b0);
    run_rec(rand_word(), 12, 1'b0, 1'b0);
    // R7: empty markers with both code settings, odd length ignored
    run_rec({112{1'b1}}, 9, 1'b1, 1'b1);
    run_rec({112{1'b1}}, 9, 1'b1, 1'b0);
    idle(1);
    run_rec(rand_word(), 5, 1'b0, 1'b1);
    // R9 is covered by the scramble inside every record

    for (int r = 0; r < 80; r++) begin
      bit e;
      e = (($urandom() % 6) == 0);
      run_rec(rand_word(), int'($urandom() % 16), e, 1'($urandom()));
      if (($urandom() % 3) == 0) idle(int'($urandom() % 3) + 1);
    end
    idle(2);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule